// File: doc/BRIEF.md
# Statistical Online Baseline Restorer

This block sits on one ADC channel, in front of pulse processing. It removes slow DC drift from a free-running sample stream. It keeps one baseline estimate in a register and subtracts that estimate from every valid sample. The result is a signed, zero-centred waveform that leaves the block one cycle after the sample arrives. No processor takes part: the block corrects its own estimate from the samples it sees.

A programmable threshold decides whether a sample is baseline. A sample whose excess over the estimate reaches the threshold is treated as part of a detector pulse and plays no part in the estimate. The accepted samples are grouped into windows of a programmable length. During a window, one counter counts the accepted samples and the other counts how many of them were strictly above the estimate. When the window closes, the estimate moves by one LSB toward the side that holds the majority. Because the estimate depends on counts and not on amplitudes, pile-up and large pulse tails do not pull it.

The datapath is small so that hundreds of channels fit on one device. It uses two counters, one comparator, one register and one saturating subtractor.

Top module: `sbl_restorer`

## Requirements
- R1: While reset is applied and after it is released, the baseline equals `init_base`, `out_valid` is 0 and both window counters are empty. `rst_n` is asynchronous and active low, and its release is synchronised internally over two clock edges.
- R2: For a cycle with `smp_valid`=1, the next cycle shows `out_valid`=1 and `out_data` = `smp_data` minus the baseline held in the sample's own cycle. `out_valid` is 0 in every other cycle.
- R3: The subtraction saturates to the signed DATA_W-bit range [-2^(DATA_W-1), 2^(DATA_W-1)-1]. It never wraps.
- R4: A valid sample is accepted as baseline when (`smp_data` - baseline), taken as a signed value, is less than `thresh`. Negative differences are always accepted. A rejected sample changes neither counter nor the baseline.
- R5: A window closes on the accepted sample that brings the accepted count to max(`win_len`,1), so `win_len`=0 behaves as 1. A sample counts as above only when `smp_data` > baseline. Equal counts as not above.
- R6: Let A be the above-count of the closing window, including the closing sample, and let N be max(`win_len`,1). The baseline rises by 1 if 2A > N, falls by 1 if 2A < N, and holds if 2A = N. The new value appears in the cycle after the closing sample, and both counters restart from zero.
- R7: The baseline saturates. A fall at 0 leaves it at 0, and a rise at 2^DATA_W-1 leaves it there.
- R8: A cycle with `smp_valid`=0 changes neither the counters nor the baseline.
- R9: Under a slowly drifting level with noise and frequent large pulses, the baseline stays within a few LSB of the true level once it has started near that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Unsigned ADC sample |
| thresh | input | DATA_W | Pulse rejection threshold (unsigned) |
| win_len | input | CNT_W | Accepted samples per window (0 means 1) |
| init_base | input | DATA_W | Baseline loaded during reset |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | DATA_W | Signed corrected sample |
| baseline | output | DATA_W | Current baseline estimate |

## Verification
A wrong count or a wrong comparator decision does not show at once. It shows as a baseline step that is off by one LSB, or that lands in the wrong cycle, one cycle after a window should have closed. The bench compares the `baseline` port against its own model on every cycle, so such a step is caught at the first window where it diverges. A wrong subtraction or wrong saturation shows on `out_data` one cycle after the sample that triggered it. Short windows make decision faults appear within a few samples, and a long random run with pulses exposes errors in rejection and tracking.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/sbr_rst_sync.sv
module sbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sbr_classifier.sv
module sbr_classifier #(
  parameter int DATA_W = 12
) (
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] thresh,
  output logic              accept,
  output logic              above
);
  localparam int DIFF_W = DATA_W + 1;

  logic signed [DIFF_W-1:0] excess;
  logic signed [DIFF_W-1:0] limit;

  always_comb begin
    excess = $signed({1'b0, smp_data}) - $signed({1'b0, base});
    limit  = $signed({1'b0, thresh});
    accept = smp_valid && (excess < limit);
    above  = accept && (smp_data > base);
  end
endmodule

// File: rtl/sbr_window_stats.sv
module sbr_window_stats
  import sbr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             accept,
  input  logic             above,
  input  logic [CNT_W-1:0] win_len,
  output step_e            step
);
  localparam int CMP_W = CNT_W + 2;

  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] win_eff;
  logic [CNT_W:0]   hi_total;
  logic [CMP_W-1:0] twice_hi;
  logic [CMP_W-1:0] span;
  logic             close_win;

  always_comb begin
    win_eff   = (win_len == '0) ? CNT_W'(1) : win_len;
    close_win = accept && (len_q >= (win_eff - CNT_W'(1)));
    hi_total  = {1'b0, hi_q} + {{CNT_W{1'b0}}, above};
    twice_hi  = {1'b0, hi_total} << 1;
    span      = {2'b00, win_eff};
    len_d     = len_q;
    hi_d      = hi_q;
    step      = STEP_HOLD;
    if (close_win) begin
      len_d = '0;
      hi_d  = '0;
      if (twice_hi > span)      step = STEP_UP;
      else if (twice_hi < span) step = STEP_DOWN;
      else                      step = STEP_HOLD;
    end else if (accept) begin
      len_d = len_q + CNT_W'(1);
      hi_d  = hi_total[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      len_q <= '0;
      hi_q  <= '0;
    end else if (accept) begin
      len_q <= len_d;
      hi_q  <= hi_d;
    end
  end
endmodule

// File: rtl/sbr_baseline_reg.sv
module sbr_baseline_reg
  import sbr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [DATA_W-1:0] init_base,
  input  step_e             step,
  output logic [DATA_W-1:0] base
);
  localparam logic [DATA_W-1:0] BASE_MAX = {DATA_W{1'b1}};

  logic [DATA_W-1:0] base_q, base_d;
  logic              base_en;

  always_comb begin
    base_d  = base_q;
    base_en = 1'b0;
    if (!rst_sync_n) begin
      base_d  = init_base;
      base_en = 1'b1;
    end else if (step == STEP_UP && base_q != BASE_MAX) begin
      base_d  = base_q + DATA_W'(1);
      base_en = 1'b1;
    end else if (step == STEP_DOWN && base_q != '0) begin
      base_d  = base_q - DATA_W'(1);
      base_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (base_en) base_q <= base_d;
  end

  assign base = base_q;
endmodule

// File: rtl/sbr_subtract.sv
module sbr_subtract #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] base,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int DIFF_W = DATA_W + 1;
  localparam logic signed [DIFF_W-1:0] OUT_HI = DIFF_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [DIFF_W-1:0] OUT_LO = -DIFF_W'(1 << (DATA_W-1));

  logic signed [DIFF_W-1:0] diff;
  logic        [DATA_W-1:0] sat_d;

  always_comb begin
    diff = $signed({1'b0, smp_data}) - $signed({1'b0, base});
    if (diff > OUT_HI)      sat_d = OUT_HI[DATA_W-1:0];
    else if (diff < OUT_LO) sat_d = OUT_LO[DATA_W-1:0];
    else                    sat_d = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= smp_valid;
  end

  always_ff @(posedge clk) begin
    if (smp_valid) out_data <= sat_d;
  end
endmodule

// File: rtl/sbl_restorer.sv
module sbl_restorer
  import sbr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] thresh,
  input  logic [CNT_W-1:0]  win_len,
  input  logic [DATA_W-1:0] init_base,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] baseline
);
  logic  rst_sync_n;
  logic  accept;
  logic  above;
  step_e step;

  sbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbr_classifier #(.DATA_W(DATA_W)) u_cls (
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .base      (baseline),
    .thresh    (thresh),
    .accept    (accept),
    .above     (above)
  );

  sbr_window_stats #(.CNT_W(CNT_W)) u_win (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .accept     (accept),
    .above      (above),
    .win_len    (win_len),
    .step       (step)
  );

  sbr_baseline_reg #(.DATA_W(DATA_W)) u_base (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .init_base  (init_base),
    .step       (step),
    .base       (baseline)
  );

  sbr_subtract #(.DATA_W(DATA_W)) u_sub (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .base       (baseline),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              accept,
  input logic [DATA_W-1:0] baseline,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= 1'b1;
  end

  // R2: strobe follows the input strobe by exactly one cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_q |-> (out_valid == $past(smp_valid)));

  // R6: baseline moves at most one LSB per cycle
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_q |-> ((baseline == $past(baseline)) ||
               (baseline == $past(baseline) + DATA_W'(1)) ||
               (baseline == $past(baseline) - DATA_W'(1))));

  // R4: a rejected sample cannot move the baseline
  a_r4_reject_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && smp_valid && !accept) |=> $stable(baseline));

  // R8: idle cycles leave the baseline alone
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && !smp_valid) |=> $stable(baseline));

  // R3: a sample above the baseline never yields a negative output
  a_r3_sign: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && smp_valid && (smp_data > baseline)) |=> !out_data[DATA_W-1]);
endmodule

bind sbl_restorer sbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .accept     (accept),
  .baseline   (baseline),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/tb_sbl_restorer.sv
module tb_sbl_restorer;
  localparam int DATA_W = 12;
  localparam int CNT_W  = 16;
  localparam int MAXV   = (1 << DATA_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              smp_valid;
  logic [DATA_W-1:0] smp_data;
  logic [DATA_W-1:0] thresh;
  logic [CNT_W-1:0]  win_len;
  logic [DATA_W-1:0] init_base;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic [DATA_W-1:0] baseline;

  int n_cmp = 0;
  int n_bad = 0;
  int m_base, m_len, m_hi;
  bit done = 0;

  sbl_restorer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .win_len(win_len), .init_base(init_base),
    .out_valid(out_valid), .out_data(out_data), .baseline(baseline)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int sat_out(int d);
    int hi = (1 << (DATA_W-1)) - 1;
    int lo = -(1 << (DATA_W-1));
    if (d > hi) return hi;
    if (d < lo) return lo;
    return d;
  endfunction

  function automatic int as_signed(logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? int'(v) - (1 << DATA_W) : int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample cycle: drive at negedge, check at the following negedge
  task automatic cycle(bit v, int d);
    int exp_o, n, a;
    bit acc, up;
    smp_valid = v;
    smp_data  = DATA_W'(d);
    exp_o = sat_out(d - m_base);
    acc = v && ((d - m_base) < int'(thresh));
    up  = acc && (d > m_base);
    if (acc) begin
      n = (win_len == 0) ? 1 : int'(win_len);
      if (m_len >= n - 1) begin
        a = m_hi + (up ? 1 : 0);
        if (2*a > n && m_base < MAXV) m_base++;
        else if (2*a < n && m_base > 0) m_base--;
        m_len = 0; m_hi = 0;
      end else begin
        m_len++; m_hi += up ? 1 : 0;
      end
    end
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), int'(v));
    if (v) check("R2/R3 out_data", as_signed(out_data), exp_o);
    check("R4/R5/R6/R7/R8 baseline", int'(baseline), m_base);
  endtask

  task automatic do_reset(int init, int th, int wl);
    rst_n = 0; smp_valid = 0; smp_data = '0;
    init_base = DATA_W'(init); thresh = DATA_W'(th); win_len = CNT_W'(wl);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_base = init; m_len = 0; m_hi = 0;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 baseline", int'(baseline), init);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int level, amp, plen;
    void'($urandom(32'd4242));
    rst_n = 0;
    @(negedge clk);

    // R1, R5, R6: exact half holds, majority moves up
    do_reset(100, 50, 4);
    cycle(1, 101); cycle(1, 101); cycle(1, 100); cycle(1, 99);
    check("R6 hold at half", int'(baseline), 100);
    cycle(1, 101); cycle(1, 101); cycle(1, 101); cycle(1, 100);
    check("R6 step up", int'(baseline), 101);
    cycle(1, 90); cycle(1, 90); cycle(1, 102); cycle(1, 90);
    check("R6 step down", int'(baseline), 100);

    // R8: idle cycles in mid window
    cycle(1, 120); cycle(0, 0); cycle(0, 0); cycle(1, 120);
    check("R8 idle no change", int'(baseline), 100);
    cycle(1, 120); cycle(1, 120);
    check("R8 window resumes", int'(baseline), 101);

    // R4: pulse samples rejected across many windows
    for (int i = 0; i < 40; i++) cycle(1, 101 + 50 + i);
    check("R4 pulses ignored", int'(baseline), 101);

    // R3: saturation both ways
    do_reset(MAXV, 50, 4);
    cycle(1, 0);
    check("R3 low saturation", as_signed(out_data), -(1 << (DATA_W-1)));
    do_reset(0, 50, 4);
    cycle(1, MAXV);
    check("R3 high saturation", as_signed(out_data), (1 << (DATA_W-1)) - 1);

    // R7: floor at zero, R5: win_len 0 acts as 1
    do_reset(0, 50, 0);
    for (int i = 0; i < 6; i++) cycle(1, 0);
    check("R7 floor", int'(baseline), 0);
    cycle(1, 5); cycle(1, 5);
    check("R5 win_len zero", int'(baseline), 2);

    // R9: drifting level with noise and pulses
    level = 700;
    do_reset(695, 40, 16);
    plen = 0; amp = 0;
    for (int i = 0; i < 20000; i++) begin
      if (i % 1500 == 0 && i > 0) level++;
      if (plen == 0 && ($urandom % 100) < 15) begin
        plen = 1 + $urandom % 6;
        amp  = 200 + $urandom % 1800;
      end
      if (($urandom % 10) == 0) cycle(0, 0);
      else if (plen > 0) begin
        cycle(1, (level + amp > MAXV) ? MAXV : level + amp);
        plen--;
        amp = amp / 2;
      end else cycle(1, level + int'($urandom % 7) - 3);
    end
    check("R9 tracking", (int'(baseline) - level <= 4 && level - int'(baseline) <= 4) ? 1 : 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule